// File: doc/BRIEF.md
# Crosspoint Routing Command Controller

This block holds the routing state for an 8-output by 8-input video crosspoint. A host writes one 7-bit word at a time to a parallel port. The word is a 3-bit output number and a 4-bit code, and the write strobe is qualified by two chip enables of opposite polarity. A code can pick the input for one output. Other codes switch outputs on or off, either one output or all of them.

Each output keeps its choice in two 4-bit stages, a master stage and a slave stage. A write loads the master stage. The slave stage drives the routing outputs, and a strap selects how it is updated:

- **Level strap (low):** the slave stage follows the master stage while the latch input is low.
- **Edge strap (high):** every slave stage takes its master value together on a rising edge of the latch input.

Enable commands do not use this two-stage path and act at the write edge. The write and latch inputs are asynchronous. They are brought into the system clock domain and their rising edges are detected there.

Top module: `xbar_route_ctrl`

## Requirements
- R1: After reset every output is disabled (`outEnable` = 0) and every output selects input 0 (`routeSel` = 0).
- R2: A write is recognised only when `wrStrobe`, `ceHi` and the inverse of `ceLoN` are all high, and only on the rising edge of that combination. A write with either chip enable inactive changes neither output.
- R3: A code from 0 to 7 (code[3] = 0) loads that code into the master stage of the output named by `portAddr`. No other output's master stage changes.
- R4: With `edgeMode` = 0 and `latchIn` low, each output's field in `routeSel` follows its master stage. `routeSel` field k is bits [4k+3:4k].
- R5: With `edgeMode` = 0 and `latchIn` high, `routeSel` holds. Once `latchIn` returns low, `routeSel` takes the master values.
- R6: With `edgeMode` = 1, `routeSel` changes only on a rising edge of `latchIn`. On that edge every field takes its master value together.
- R7: Code 1011 clears and code 1100 sets the `outEnable` bit of the addressed output. Both act at the write edge for any value of `latchIn` or `edgeMode`.
- R8: Code 1101 clears all `outEnable` bits and code 1110 sets all of them.
- R9: Codes 1000, 1001, 1010 and 1111 change neither `routeSel` nor `outEnable`.
- R10: Disabling an output leaves its `routeSel` field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| portAddr | input | 3 | Output number of the command |
| portCode | input | 4 | Input index or command code |
| wrStrobe | input | 1 | Write strobe (asynchronous, rising edge acts) |
| ceHi | input | 1 | Active-high chip enable |
| ceLoN | input | 1 | Active-low chip enable |
| latchIn | input | 1 | Latch strobe (asynchronous) |
| edgeMode | input | 1 | Strap: 0 = slave transparent while latch low, 1 = slave loads on latch rise |
| routeSel | output | 32 | Slave-stage selection, 4 bits per output, output 0 in the low bits |
| outEnable | output | 8 | Per-output enable, bit k for output k |

## Verification
**Routing writes in level mode.** Writes are issued with the latch low, then held high, then released. These cases show the difference between a slave stage that is transparent and one that is holding.

**Writes in edge mode.** Several writes are queued to different outputs before one latch rise. This shows whether all fields move together, and only on that rise.

**Enable commands and gating.** Enable commands are sent while the latch is held high and also in edge mode, to confirm they bypass the latch path. Writes with one chip enable inactive, and the unused codes, must leave both outputs unchanged. This separates the gating and decoding from the register path.

// File: rtl/xbar_route_pkg.sv
package xbar_route_pkg;
  parameter int NUM_OUT = 8;
  parameter int CODE_W  = 4;
  parameter int ADDR_W  = $clog2(NUM_OUT);

  localparam logic [CODE_W-1:0] CMD_DIS_ONE = 4'b1011;
  localparam logic [CODE_W-1:0] CMD_EN_ONE  = 4'b1100;
  localparam logic [CODE_W-1:0] CMD_DIS_ALL = 4'b1101;
  localparam logic [CODE_W-1:0] CMD_EN_ALL  = 4'b1110;

  typedef struct packed {
    logic              loadSel;
    logic              enOne;
    logic              disOne;
    logic              enAll;
    logic              disAll;
    logic              slaveXfer;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] sel;
  } ctlStb_t;
endpackage

// File: rtl/xbar_route_cmd.sv
module xbar_route_cmd
  import xbar_route_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic [CODE_W-1:0] portCode,
  input  logic              wrStrobe,
  input  logic              ceHi,
  input  logic              ceLoN,
  input  logic              latchIn,
  input  logic              edgeMode,
  output ctlStb_t           stb
);
  localparam int TOP = SYNC_STAGES - 1;

  logic                   wrEff;
  logic [SYNC_STAGES-1:0] wrSync;
  logic [SYNC_STAGES-1:0] latSync;
  logic                   wrPrev;
  logic                   latPrev;
  logic                   wrRise;
  logic                   latRise;
  logic                   latLow;

  assign wrEff = wrStrobe & ceHi & ~ceLoN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSync  <= '0;
      latSync <= '1;
      wrPrev  <= 1'b0;
      latPrev <= 1'b1;
    end else begin
      wrSync  <= {wrSync[TOP-1:0], wrEff};
      latSync <= {latSync[TOP-1:0], latchIn};
      wrPrev  <= wrSync[TOP];
      latPrev <= latSync[TOP];
    end
  end

  assign wrRise  = wrSync[TOP] & ~wrPrev;
  assign latRise = latSync[TOP] & ~latPrev;
  assign latLow  = ~latSync[TOP];

  always_comb begin
    stb           = '0;
    stb.addr      = portAddr;
    stb.sel       = portCode;
    stb.slaveXfer = edgeMode ? latRise : latLow;
    if (wrRise) begin
      if (!portCode[CODE_W-1]) begin
        stb.loadSel = 1'b1;
      end else begin
        unique case (portCode)
          CMD_DIS_ONE: stb.disOne = 1'b1;
          CMD_EN_ONE:  stb.enOne  = 1'b1;
          CMD_DIS_ALL: stb.disAll = 1'b1;
          CMD_EN_ALL:  stb.enAll  = 1'b1;
          default:     ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xbar_route_regs.sv
module xbar_route_regs
  import xbar_route_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStb_t                   stb,
  output logic [NUM_OUT*CODE_W-1:0] masterFlat,
  output logic [NUM_OUT*CODE_W-1:0] routeSel,
  output logic [NUM_OUT-1:0]        outEnable
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic [CODE_W-1:0] masterR;
    logic [CODE_W-1:0] slaveR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        masterR <= '0;
        slaveR  <= '0;
      end else begin
        if (stb.loadSel && stb.addr == ADDR_W'(g)) masterR <= stb.sel;
        if (stb.slaveXfer) slaveR <= masterR;
      end
    end

    assign masterFlat[g*CODE_W +: CODE_W] = masterR;
    assign routeSel[g*CODE_W +: CODE_W]   = slaveR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outEnable <= '0;
    end else if (stb.disAll) begin
      outEnable <= '0;
    end else if (stb.enAll) begin
      outEnable <= '1;
    end else if (stb.enOne) begin
      outEnable[stb.addr] <= 1'b1;
    end else if (stb.disOne) begin
      outEnable[stb.addr] <= 1'b0;
    end
  end
endmodule

// File: rtl/xbar_route_ctrl.sv
module xbar_route_ctrl
  import xbar_route_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         portAddr,
  input  logic [CODE_W-1:0]         portCode,
  input  logic                      wrStrobe,
  input  logic                      ceHi,
  input  logic                      ceLoN,
  input  logic                      latchIn,
  input  logic                      edgeMode,
  output logic [NUM_OUT*CODE_W-1:0] routeSel,
  output logic [NUM_OUT-1:0]        outEnable
);
  ctlStb_t                   ctlStb;
  logic [NUM_OUT*CODE_W-1:0] masterFlat;

  xbar_route_cmd #(.SYNC_STAGES(SYNC_STAGES)) u_cmd (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .portCode(portCode),
    .wrStrobe(wrStrobe), .ceHi(ceHi), .ceLoN(ceLoN), .latchIn(latchIn),
    .edgeMode(edgeMode), .stb(ctlStb)
  );

  xbar_route_regs u_regs (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .masterFlat(masterFlat),
    .routeSel(routeSel), .outEnable(outEnable)
  );
endmodule

// File: rtl/xbar_route_chk.sv
module xbar_route_chk
  import xbar_route_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input ctlStb_t                   stb,
  input logic [NUM_OUT*CODE_W-1:0] masterFlat,
  input logic [NUM_OUT*CODE_W-1:0] routeSel,
  input logic [NUM_OUT-1:0]        outEnable
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (outEnable == '0 && routeSel == '0));

  a_r3_master_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadSel |=> masterFlat[$past(stb.addr)*CODE_W +: CODE_W] == $past(stb.sel));

  a_r4_slave_copy: assert property (@(posedge clk) disable iff (!rstN)
    stb.slaveXfer |=> routeSel == $past(masterFlat));

  a_r6_route_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.slaveXfer |=> $stable(routeSel));

  a_r7_enable_only_cmd: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.enOne || stb.disOne || stb.enAll || stb.disAll) |=> $stable(outEnable));

  a_r8_enable_all: assert property (@(posedge clk) disable iff (!rstN)
    stb.enAll |=> outEnable == '1);

  a_r8_disable_all: assert property (@(posedge clk) disable iff (!rstN)
    stb.disAll |=> outEnable == '0);
endmodule

bind xbar_route_ctrl xbar_route_chk u_chk (
  .clk(clk), .rstN(rstN), .stb(ctlStb), .masterFlat(masterFlat),
  .routeSel(routeSel), .outEnable(outEnable)
);

// File: tb/xbar_route_ctrl_tb.sv
module xbar_route_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  portAddr = '0;
  logic [3:0]  portCode = '0;
  logic        wrStrobe = 1'b0;
  logic        ceHi = 1'b1;
  logic        ceLoN = 1'b0;
  logic        latchIn = 1'b0;
  logic        edgeMode = 1'b0;
  logic [31:0] routeSel;
  logic [7:0]  outEnable;

  int total = 0;
  int bad = 0;
  logic [3:0] expMaster [8];
  logic [3:0] expSlave  [8];
  logic [7:0] expEn;

  always #2.5 clk = ~clk;

  xbar_route_ctrl u_dut (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .portCode(portCode),
    .wrStrobe(wrStrobe), .ceHi(ceHi), .ceLoN(ceLoN), .latchIn(latchIn),
    .edgeMode(edgeMode), .routeSel(routeSel), .outEnable(outEnable)
  );

  function automatic logic [31:0] expRoute();
    logic [31:0] v;
    for (int k = 0; k < 8; k++) v[k*4 +: 4] = expSlave[k];
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic chkAll(string req);
    chk({req, " route"}, routeSel, expRoute());
    chk({req, " enable"}, {24'd0, outEnable}, {24'd0, expEn});
  endtask

  task automatic settle(int n = 8);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(logic [2:0] a, logic [3:0] c);
    @(negedge clk);
    portAddr = a;
    portCode = c;
    wrStrobe = 1'b1;
    settle(4);
    wrStrobe = 1'b0;
    settle(5);
  endtask

  task automatic model(logic [2:0] a, logic [3:0] c);
    if (!c[3]) expMaster[a] = c;
    else if (c == 4'b1011) expEn[a] = 1'b0;
    else if (c == 4'b1100) expEn[a] = 1'b1;
    else if (c == 4'b1101) expEn = '0;
    else if (c == 4'b1110) expEn = '1;
  endtask

  task automatic copySlaves();
    for (int k = 0; k < 8; k++) expSlave[k] = expMaster[k];
  endtask

  task automatic t_reset();
    settle(2);
    chkAll("R1");
  endtask

  task automatic t_level();
    doWrite(3'd3, 4'd5); model(3'd3, 4'd5); copySlaves();
    chkAll("R3 R4 single write");
    doWrite(3'd0, 4'd7); model(3'd0, 4'd7); copySlaves();
    chkAll("R4 second output");
  endtask

  task automatic t_ce();
    ceHi = 1'b0;
    doWrite(3'd1, 4'd6);
    chkAll("R2 ceHi low");
    ceHi = 1'b1; ceLoN = 1'b1;
    doWrite(3'd1, 4'd6);
    chkAll("R2 ceLoN high");
    ceLoN = 1'b0;
  endtask

  task automatic t_latchHold();
    latchIn = 1'b1; settle();
    doWrite(3'd2, 4'd4); model(3'd2, 4'd4);
    chkAll("R5 hold while latch high");
    latchIn = 1'b0; settle(); copySlaves();
    chkAll("R5 release");
  endtask

  task automatic t_enable();
    latchIn = 1'b1; settle();
    doWrite(3'd5, 4'b1100); model(3'd5, 4'b1100);
    chkAll("R7 enable with latch high");
    edgeMode = 1'b1; settle();
    doWrite(3'd6, 4'b1100); model(3'd6, 4'b1100);
    chkAll("R7 enable in edge mode");
    doWrite(3'd5, 4'b1011); model(3'd5, 4'b1011);
    chkAll("R7 disable one");
    edgeMode = 1'b0; latchIn = 1'b0; settle();
  endtask

  task automatic t_all();
    doWrite(3'd0, 4'b1110); model(3'd0, 4'b1110);
    chkAll("R8 enable all");
    doWrite(3'd4, 4'b1101); model(3'd4, 4'b1101);
    chkAll("R8 disable all");
    doWrite(3'd2, 4'b1110); model(3'd2, 4'b1110);
    chkAll("R8 enable all again");
  endtask

  task automatic t_noop();
    doWrite(3'd3, 4'b1000); chkAll("R9 code 1000");
    doWrite(3'd3, 4'b1001); chkAll("R9 code 1001");
    doWrite(3'd3, 4'b1010); chkAll("R9 code 1010");
    doWrite(3'd3, 4'b1111); chkAll("R9 code 1111");
  endtask

  task automatic t_disableKeep();
    doWrite(3'd3, 4'b1011); model(3'd3, 4'b1011);
    chkAll("R10 route kept after disable");
  endtask

  task automatic t_edge();
    edgeMode = 1'b1; latchIn = 1'b0; settle();
    doWrite(3'd1, 4'd2); model(3'd1, 4'd2);
    doWrite(3'd7, 4'd6); model(3'd7, 4'd6);
    chkAll("R6 hold before latch rise");
    latchIn = 1'b1; settle(); copySlaves();
    chkAll("R6 all update on rise");
    doWrite(3'd4, 4'd3); model(3'd4, 4'd3);
    latchIn = 1'b0; settle();
    chkAll("R6 no update on fall or level");
    latchIn = 1'b1; settle(); copySlaves();
    chkAll("R6 second rise");
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin expMaster[k] = '0; expSlave[k] = '0; end
    expEn = '0;
    settle(3);
    rstN = 1'b1;
    t_reset();
    t_level();
    t_ce();
    t_latchHold();
    t_enable();
    t_all();
    t_noop();
    t_disableKeep();
    t_edge();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1-all actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule